// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block collects up to eighteen asynchronous interrupt inputs and presents them to two independent hosts. Every input is synchronised, and then an edge detector looks for a change on it. Which edges count is chosen per input by a two-bit edge code. The edge codes sit in one configuration area that both hosts share. An accepted edge sets the input's status bit in both host lines at once. Each line keeps its own status and mask registers, so each host decides for itself which inputs may pull its active-low interrupt output.

Software reaches every register through a simple byte-wide synchronous bus. Read data is registered. A control register picks how status is acknowledged. In one mode, reading a status byte clears the bits it returned. In the other mode, software writes ones to the status byte to clear those bits. A second control bit picks what happens to an edge that arrives while its status bit is still set: the edge is either held back for later or thrown away. A summary byte shows, for each line, whether any unmasked status bit is pending.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every status bit is 0, every mask byte reads 0xFF, every edge-code byte reads 0x00, the control byte reads 0x00, and both irq_n outputs are high.
- R2: Input i takes its edge code from edge byte i/4 (address 0x30 + i/4), bits (i mod 4)*2+1 and (i mod 4)*2. The upper bit of the pair enables rising edges and the lower bit enables falling edges. With both bits set, either edge is accepted.
- R3: An input whose edge code is 00 never sets a status bit, whatever its pin does.
- R4: An accepted edge on input i sets bit i mod 8 of status byte i/8 in both lines, even where a line masks that input. Line 0 status is at 0x10 + k and its mask at 0x18 + k. Line 1 status is at 0x20 + k and its mask at 0x28 + k.
- R5: irq_n[l] is low exactly when line l has a status bit set whose mask bit is 0. The output is registered, so it follows the status one cycle later. A mask bit of 1 hides that input from the line.
- R6: Reading address 0x01 returns one summary bit per line: bit 0 for line 0 and bit 1 for line 1. A summary bit is 1 when that line has an unmasked pending status bit.
- R7: The control byte is at address 0x00. When its bit 0 is 1, reading a status byte clears, in that line only, the bits the read returned, and writes to status bytes have no effect.
- R8: When control bit 0 is 0, reading a status byte leaves it unchanged. Writing a status byte clears the bits written as 1 and keeps the bits written as 0.
- R9: Control bit 1 handles an edge that arrives while its status bit is already set. When bit 1 is 0, one such edge is held, and the status bit sets again within two cycles after it is cleared. When bit 1 is 1, the edge is dropped.
- R10: If an accepted edge and a clear of the same status bit fall in the same cycle, the bit stays set.
- R11: Read data appears on bus_rdata in the cycle after the read. Unmapped addresses read 0x00, and bus_rdata is 0x00 after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_INPUTS | Asynchronous interrupt inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt, one per host line |

## Verification
The assertions check, on every cycle, the rules that can be stated cycle by cycle. An edge always lands in both lines. A clear with no competing edge always takes effect. An output always follows the unmasked status of the cycle before. When control bit 1 is set, no edge is ever held. An edge only fires on a real change of the synchronised input. The bench scenarios cover what needs a sequence of register operations: the edge-code field positions, the ordering of a held edge across a clear, a clear on read that touches only one line, and an edge landing in the exact cycle of a clear. Random input patterns with random edge codes and masks are checked against a bench model of both status registers.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned MAX_INPUTS = 18;

  // address windows: addr[7:3] selects window, addr[2:0] selects byte
  localparam logic [4:0] WIN_CTRL = 5'd0;
  localparam logic [4:0] WIN_ISR0 = 5'd2;
  localparam logic [4:0] WIN_IMR0 = 5'd3;
  localparam logic [4:0] WIN_EDGE = 5'd6;

  localparam int unsigned CTRL_COR_BIT = 0;
  localparam int unsigned CTRL_HOLDOFF_BIT = 1;

  function automatic int unsigned bytes_for(input int unsigned bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/sic_edge_detect.sv
module sic_edge_detect #(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   pin_i,
  input  logic [2*N-1:0] edge_cfg_i,
  output logic [N-1:0]   event_o
);
  logic [N-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign event_o[i] = (edge_cfg_i[2*i+1] &  sync_q[i] & ~last_q[i])
                      | (edge_cfg_i[2*i]   & ~sync_q[i] &  last_q[i]);

    // R2: an event only fires on a real change of the synchronised input
    p_event_on_change_r2: assert property (@(posedge clk) disable iff (rst)
      event_o[i] |-> (sync_q[i] != last_q[i]));
  end
endmodule

// File: rtl/sic_line.sv
module sic_line #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] event_i,
  input  logic         holdoff_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  output logic [W-1:0] isr_o,
  output logic [W-1:0] imr_o,
  output logic         pend_o,
  output logic         irq_n_o
);
  logic [W-1:0] isr_q, imr_q, held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q   <= '0;
      held_q  <= '0;
      imr_q   <= '1;
      irq_n_o <= 1'b1;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (event_i[i]) begin
          if (isr_q[i] && !clr_i[i]) begin
            if (!holdoff_i) held_q[i] <= 1'b1;
          end else begin
            isr_q[i] <= 1'b1;
          end
        end else if (clr_i[i]) begin
          isr_q[i] <= 1'b0;
        end else if (!isr_q[i] && held_q[i]) begin
          isr_q[i]  <= 1'b1;
          held_q[i] <= 1'b0;
        end
        if (mask_we_i[i]) imr_q[i] <= mask_wd_i[i];
      end
      irq_n_o <= ~|(isr_q & ~imr_q);
    end
  end

  assign isr_o  = isr_q;
  assign imr_o  = imr_q;
  assign pend_o = |(isr_q & ~imr_q);

  // R1: state right after reset
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (imr_q == '1 && isr_q == '0 && irq_n_o));
  // R4: every edge is present in status the next cycle
  p_edge_lands_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(event_i) & ~isr_q) == '0));
  // R5: output follows unmasked status one cycle later
  p_line_out_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n_o == !$past(pend_o)));
  // R8: a clear with no competing edge takes effect
  p_clear_takes_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(clr_i & ~event_i) & isr_q) == '0));
  // R9: with hold-off set no edge is ever held
  p_drop_when_holdoff_r9: assert property (@(posedge clk) disable iff (rst)
    holdoff_i |=> ((held_q & ~$past(held_q)) == '0));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int unsigned N_INPUTS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_INPUTS-1:0] irq_in,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic [1:0]          irq_n
);
  import sic_pkg::*;

  localparam int unsigned STAT_BYTES = bytes_for(N_INPUTS);
  localparam int unsigned EDGE_BYTES = bytes_for(2 * N_INPUTS);
  localparam int unsigned W = 8 * STAT_BYTES;

  logic [4:0] win;
  logic [2:0] idx;
  logic       wr_en, rd_en;
  assign win   = bus_addr[7:3];
  assign idx   = bus_addr[2:0];
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  logic                    cor_q, holdoff_q;
  logic [8*EDGE_BYTES-1:0] edge_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cor_q     <= 1'b0;
      holdoff_q <= 1'b0;
      edge_q    <= '0;
    end else if (wr_en) begin
      if (win == WIN_CTRL && idx == 3'd0) begin
        cor_q     <= bus_wdata[CTRL_COR_BIT];
        holdoff_q <= bus_wdata[CTRL_HOLDOFF_BIT];
      end
      for (int k = 0; k < EDGE_BYTES; k++)
        if (win == WIN_EDGE && idx == 3'(k)) edge_q[k*8 +: 8] <= bus_wdata;
    end
  end

  logic [N_INPUTS-1:0] event_w;
  logic [W-1:0]        event_pad;

  sic_edge_detect #(.N(N_INPUTS)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (irq_in),
    .edge_cfg_i (edge_q[2*N_INPUTS-1:0]),
    .event_o    (event_w)
  );

  always_comb begin
    event_pad = '0;
    event_pad[N_INPUTS-1:0] = event_w;
  end

  logic [W-1:0] isr_l [2];
  logic [W-1:0] imr_l [2];
  logic [1:0]   pend_l;

  for (genvar l = 0; l < 2; l++) begin : g_line
    localparam logic [4:0] ISR_WIN = WIN_ISR0 + 5'(2 * l);
    localparam logic [4:0] IMR_WIN = WIN_IMR0 + 5'(2 * l);
    logic [W-1:0] clr, mwe, mwd;

    always_comb begin
      clr = '0;
      mwe = '0;
      mwd = '0;
      for (int k = 0; k < STAT_BYTES; k++) begin
        if (bus_sel && win == ISR_WIN && idx == 3'(k)) begin
          if (bus_wr && !cor_q) clr[k*8 +: 8] = bus_wdata;
          if (!bus_wr && cor_q) clr[k*8 +: 8] = isr_l[l][k*8 +: 8];
        end
        if (wr_en && win == IMR_WIN && idx == 3'(k)) begin
          mwe[k*8 +: 8] = 8'hFF;
          mwd[k*8 +: 8] = bus_wdata;
        end
      end
    end

    sic_line #(.W(W)) u_line (
      .clk       (clk),
      .rst       (rst),
      .event_i   (event_pad),
      .holdoff_i (holdoff_q),
      .clr_i     (clr),
      .mask_we_i (mwe),
      .mask_wd_i (mwd),
      .isr_o     (isr_l[l]),
      .imr_o     (imr_l[l]),
      .pend_o    (pend_l[l]),
      .irq_n_o   (irq_n[l])
    );
  end

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = 8'h00;
    if (win == WIN_CTRL) begin
      if (idx == 3'd0) rd_byte = {6'd0, holdoff_q, cor_q};
      if (idx == 3'd1) rd_byte = {6'd0, pend_l};
    end
    for (int k = 0; k < STAT_BYTES; k++) begin
      if (idx == 3'(k)) begin
        if (win == WIN_ISR0)        rd_byte = isr_l[0][k*8 +: 8];
        if (win == WIN_IMR0)        rd_byte = imr_l[0][k*8 +: 8];
        if (win == WIN_ISR0 + 5'd2) rd_byte = isr_l[1][k*8 +: 8];
        if (win == WIN_IMR0 + 5'd2) rd_byte = imr_l[1][k*8 +: 8];
      end
    end
    for (int k = 0; k < EDGE_BYTES; k++)
      if (win == WIN_EDGE && idx == 3'(k)) rd_byte = edge_q[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_en ? rd_byte : 8'h00;
  end

  // R11: no read leaves the data bus at zero
  p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (bus_rdata == 8'h00));
  // R6: summary read returns the per-line pending state of the read cycle
  p_summary_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == 8'h01) |=> (bus_rdata[1:0] == $past(pend_l)));
endmodule

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
  localparam int NI = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_in = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic [1:0]    irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_irq_ctrl #(.N_INPUTS(NI)) i_dual_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] model_events(input logic [7:0] prv, input logic [7:0] nxt,
                                              input logic [15:0] cfg);
    logic [7:0] ev = '0;
    for (int i = 0; i < NI; i++) begin
      if (cfg[2*i+1] && !prv[i] && nxt[i]) ev[i] = 1'b1;
      if (cfg[2*i]   && prv[i] && !nxt[i]) ev[i] = 1'b1;
    end
    return ev;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp0, exp1, m0, m1, prv, nxt;
    logic [15:0] cfg;
    void'($urandom(32'd4711));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", irq_n, 2'b11);
    rd(8'h18, d); chk("R1 imr0", d, 8'hFF);
    rd(8'h28, d); chk("R1 imr1", d, 8'hFF);
    rd(8'h10, d); chk("R1 isr0", d, 8'h00);
    rd(8'h30, d); chk("R1 edge", d, 8'h00);
    rd(8'h00, d); chk("R1 ctrl", d, 8'h00);

    // R3 code 00 ignores pin activity
    irq_in = 8'hFF; settle();
    irq_in = 8'h00; settle();
    rd(8'h10, d); chk("R3 isr0", d, 8'h00);
    rd(8'h20, d); chk("R3 isr1", d, 8'h00);

    // R2 field positions; R4 both lines; R5 masking
    wr(8'h18, 8'h00);            // line0 unmasked
    wr(8'h30, 8'h08);            // input1 rising
    wr(8'h31, 8'h01);            // input4 falling
    irq_in = 8'h12; settle();
    rd(8'h10, d); chk("R2 rise only input1", d, 8'h02);
    irq_in = 8'h00; settle();
    rd(8'h10, d); chk("R2 fall input4", d, 8'h12);
    rd(8'h20, d); chk("R4 masked line1 status", d, 8'h12);
    chk("R5 irq_n split", irq_n, 2'b10);
    rd(8'h01, d); chk("R6 summary", d, 8'h01);

    // R8 write-one-to-clear
    rd(8'h10, d); chk("R8 read keeps", d, 8'h12);
    wr(8'h10, 8'h02);
    rd(8'h10, d); chk("R8 partial clear", d, 8'h10);
    rd(8'h20, d); chk("R8 line1 untouched", d, 8'h12);
    wr(8'h10, 8'h10); wr(8'h20, 8'h12);
    @(negedge clk);
    chk("R5 irq_n idle", irq_n, 2'b11);
    rd(8'h01, d); chk("R6 summary idle", d, 8'h00);

    // R7 clear on read
    wr(8'h00, 8'h01);
    wr(8'h30, 8'hFF); wr(8'h31, 8'hFF);
    irq_in = 8'h01; settle();
    rd(8'h10, d); chk("R7 first read", d, 8'h01);
    rd(8'h10, d); chk("R7 cleared", d, 8'h00);
    wr(8'h20, 8'hFF);
    rd(8'h20, d); chk("R7 line1 kept, write ignored", d, 8'h01);
    rd(8'h20, d); chk("R7 line1 cleared", d, 8'h00);
    irq_in = 8'h00; settle();
    rd(8'h10, d); rd(8'h20, d);

    // R9 held edge
    wr(8'h00, 8'h00);
    irq_in = 8'h04; settle();
    irq_in = 8'h00; settle();
    wr(8'h10, 8'h04);
    settle();
    rd(8'h10, d); chk("R9 held edge returns", d, 8'h04);
    wr(8'h10, 8'h04); settle();
    rd(8'h10, d); chk("R9 single hold", d, 8'h00);
    wr(8'h20, 8'h04); settle(); wr(8'h20, 8'h04);
    wr(8'h00, 8'h02);
    irq_in = 8'h04; settle();
    irq_in = 8'h00; settle();
    wr(8'h10, 8'h04); settle();
    rd(8'h10, d); chk("R9 dropped edge", d, 8'h00);
    wr(8'h20, 8'h04);

    // R10 edge and clear in one cycle
    wr(8'h30, 8'h80); wr(8'h31, 8'h00);
    irq_in = 8'h08; settle();
    irq_in = 8'h00; settle();
    rd(8'h10, d); chk("R10 precondition", d, 8'h08);
    @(negedge clk);
    irq_in = 8'h08;
    @(posedge clk); @(posedge clk);
    wr(8'h10, 8'h08);
    rd(8'h10, d); chk("R10 edge wins", d, 8'h08);
    wr(8'h10, 8'h08);
    rd(8'h10, d); chk("R10 plain clear", d, 8'h00);
    wr(8'h20, 8'hFF);

    // R11 unmapped and idle
    rd(8'h7F, d); chk("R11 unmapped", d, 8'h00);
    @(negedge clk); chk("R11 idle bus", bus_rdata, 8'h00);

    // random edge codes, masks and pin patterns (R4 R5)
    wr(8'h00, 8'h02);
    prv = irq_in;
    for (int it = 0; it < 24; it++) begin
      cfg = 16'($urandom);
      m0 = 8'($urandom); m1 = 8'($urandom);
      wr(8'h30, cfg[7:0]); wr(8'h31, cfg[15:8]);
      wr(8'h18, m0); wr(8'h28, m1);
      nxt = 8'($urandom);
      irq_in = nxt; settle();
      exp0 = model_events(prv, nxt, cfg);
      exp1 = exp0;
      rd(8'h10, d); chk("R4 random isr0", d, exp0);
      rd(8'h20, d); chk("R4 random isr1", d, exp1);
      chk("R5 random irq_n", irq_n, {~|(exp1 & ~m1), ~|(exp0 & ~m0)});
      wr(8'h10, 8'hFF); wr(8'h20, 8'hFF);
      prv = nxt;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule